// File: doc/BRIEF.md
# Optional Cycle Alignment Resolver

This block sits beside an instruction sequencer whose program memory is read only as aligned 16-bit words. For each instruction that enters execution it decides what every optional bus slot turns into: a free cycle (no bus activity) or a program-word fetch that keeps the word-fetch queue in step. The sequencer hands over the byte address of the first byte, the byte count of the instruction and a flag that marks a page-two prebyte. The block answers with zero, one or two resolved slot codes, one per clock.

The prebyte of a page-two instruction is treated as a one-byte instruction of its own. It therefore always owns a leading optional slot. When the whole page-two instruction has an odd byte count, it also owns a trailing slot, which resolves to the opposite code of the leading one. An ordinary instruction owns a leading slot only when its byte count is odd. The block also keeps the address where the next sequential instruction starts, so that the fetch-queue parity is known across consecutive instructions.

States: `ST_IDLE` (ready for an instruction), `ST_LEAD` (presenting the leading slot) and `ST_TRAIL` (presenting the trailing slot). Transitions:
- ST_IDLE to ST_LEAD when an accepted instruction owns a leading slot.
- ST_IDLE back to ST_IDLE when there is no accepted instruction, or when the accepted one owns no slot.
- ST_LEAD to ST_TRAIL when the instruction also owns a trailing slot.
- ST_LEAD to ST_IDLE when it does not.
- ST_TRAIL to ST_IDLE always.

Top module: `opt_cycle_resolver`

## Requirements
- R1: After reset, `in_ready` is 1, `slot_valid` is 0, `next_addr` is 0 and `q_parity` is 0 (aligned).
- R2: An ordinary instruction (`in_pg2`=0) with an odd byte count whose first byte is aligned (address bit 0 = 0) produces exactly one slot, with `slot_code`=0 (free) and `slot_trail`=0. The slot appears in the cycle after the instruction is accepted.
- R3: An ordinary instruction with an odd byte count whose first byte is misaligned (address bit 0 = 1) produces exactly one slot, with `slot_code`=1 (fetch) and `slot_trail`=0.
- R4: An ordinary instruction with an even byte count produces no slot, and `in_ready` stays 1.
- R5: A page-two instruction (`in_pg2`=1) always produces a leading slot (`slot_trail`=0) whose code equals bit 0 of its first-byte address, whatever its byte count.
- R6: A page-two instruction with an odd byte count produces a trailing slot (`slot_trail`=1) in the cycle right after its leading slot. The trailing slot's code is the inverse of the leading code.
- R7: A page-two instruction with an even byte count produces only its leading slot.
- R8: `in_ready` is 0 in every cycle in which a slot is presented. An `in_valid` raised while `in_ready` is 0 is ignored: it produces no slot and leaves `next_addr` unchanged.
- R9: One cycle after an instruction is accepted, `next_addr` equals its address plus its byte count, modulo 2^ADDR_W. `q_parity` equals bit 0 of `next_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | An instruction is offered |
| in_ready | output | 1 | The block accepts an instruction this cycle |
| in_addr | input | ADDR_W | Byte address of the instruction's first byte |
| in_len | input | LEN_W | Instruction length in bytes |
| in_pg2 | input | 1 | Instruction begins with a page-two prebyte |
| slot_valid | output | 1 | A resolved optional slot is presented |
| slot_code | output | 1 | 0 = free cycle, 1 = program-word fetch |
| slot_trail | output | 1 | 0 = leading slot, 1 = trailing slot |
| next_addr | output | ADDR_W | Start address of the next sequential instruction |
| q_parity | output | 1 | Fetch-queue parity (bit 0 of `next_addr`) |

## Verification
The bench goes after all four combinations of alignment and length parity for page-two instructions. A design that fails to invert the trailing code would emit two equal codes. A design that ties the trailing slot to the ordinary-instruction rule would drop or add a slot. Even-length ordinary instructions are sent back to back with odd ones; a design that gives every instruction a slot would show an unexpected item in the scoreboard. An offer made while a two-slot page-two instruction is still being resolved must leave no trace, and an address near the top of the space checks that `next_addr` wraps.

// File: rtl/oca_pkg.sv
package oca_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_TRAIL = 2'd2
    } oca_state_e;

    typedef struct packed {
        logic has_lead;
        logic has_trail;
        logic lead_code;
    } oca_plan_t;
endpackage

// File: rtl/oca_classify.sv
module oca_classify
    import oca_pkg::*;
(
    input  logic      first_odd,
    input  logic      len_odd,
    input  logic      pg2,
    output oca_plan_t plan
);
    always_comb begin
        // a prebyte is a one-byte instruction, so page-two always owns a slot
        plan.has_lead  = pg2 | len_odd;
        plan.has_trail = pg2 & len_odd;
        plan.lead_code = first_odd;
    end
endmodule

// File: rtl/oca_tracker.sv
module oca_tracker #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    output logic [ADDR_W-1:0] next_addr
);
    logic [ADDR_W-1:0] sum;

    always_comb sum = addr + ADDR_W'(len);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      next_addr <= '0;
        else if (accept) next_addr <= sum;
    end

    a_r9_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $past(accept) |-> next_addr == $past(addr) + ADDR_W'($past(len)));
    a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(accept) |-> $stable(next_addr));
endmodule

// File: rtl/oca_fsm.sv
module oca_fsm
    import oca_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      in_valid,
    input  oca_plan_t plan,
    output logic      in_ready,
    output logic      accept,
    output logic      slot_valid,
    output logic      slot_code,
    output logic      slot_trail
);
    oca_state_e state, state_nx;
    oca_plan_t  plan_q;

    always_comb accept = in_valid & in_ready;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  state_nx = (accept && plan.has_lead) ? ST_LEAD : ST_IDLE;
            ST_LEAD:  state_nx = plan_q.has_trail ? ST_TRAIL : ST_IDLE;
            ST_TRAIL: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            plan_q <= '0;
        end else begin
            state <= state_nx;
            if (accept) plan_q <= plan;
        end
    end

    always_comb begin
        in_ready   = 1'b0;
        slot_valid = 1'b0;
        slot_trail = 1'b0;
        slot_code  = 1'b0;
        unique case (state)
            ST_IDLE:  in_ready = 1'b1;
            ST_LEAD: begin
                slot_valid = 1'b1;
                slot_code  = plan_q.lead_code;
            end
            ST_TRAIL: begin
                slot_valid = 1'b1;
                slot_trail = 1'b1;
                slot_code  = ~plan_q.lead_code;
            end
            default: in_ready = 1'b0;
        endcase
    end

    a_r2_lead_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && !slot_trail) |-> $past(accept));
    a_r6_trail_after_lead: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && slot_trail) |-> $past(slot_valid && !slot_trail));
    a_r6_trail_inverted: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && slot_trail) |-> slot_code != $past(slot_code));
    a_r4_no_slot_without_lead: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !plan.has_lead) |=> !slot_valid);
endmodule

// File: rtl/opt_cycle_resolver.sv
module opt_cycle_resolver
    import oca_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [LEN_W-1:0]  in_len,
    input  logic              in_pg2,
    output logic              slot_valid,
    output logic              slot_code,
    output logic              slot_trail,
    output logic [ADDR_W-1:0] next_addr,
    output logic              q_parity
);
    oca_plan_t plan;
    logic      accept;

    oca_classify u_classify (
        .first_odd (in_addr[0]),
        .len_odd   (in_len[0]),
        .pg2       (in_pg2),
        .plan      (plan)
    );

    oca_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .plan       (plan),
        .in_ready   (in_ready),
        .accept     (accept),
        .slot_valid (slot_valid),
        .slot_code  (slot_code),
        .slot_trail (slot_trail)
    );

    oca_tracker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .addr      (in_addr),
        .len       (in_len),
        .next_addr (next_addr)
    );

    always_comb q_parity = next_addr[0];

    a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid |-> !in_ready);
endmodule

// File: tb/tb_opt_cycle_resolver.sv
module tb_opt_cycle_resolver;
    localparam int ADDR_W = 16;
    localparam int LEN_W  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [ADDR_W-1:0] in_addr = '0;
    logic [LEN_W-1:0]  in_len = '0;
    logic in_pg2 = 1'b0;
    logic in_ready, slot_valid, slot_code, slot_trail, q_parity;
    logic [ADDR_W-1:0] next_addr;

    int checks = 0;
    int errors = 0;
    logic [1:0] expq[$];   // {trail, code}
    bit done = 0;

    always #2.5 clk = ~clk;

    opt_cycle_resolver #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) dut (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pop and compare at every negedge
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && slot_valid) begin
                if (expq.size() == 0)
                    check(0, "R4/R7/R8 unexpected slot", {slot_trail, slot_code}, 0);
                else begin
                    logic [1:0] e;
                    e = expq.pop_front();
                    check({slot_trail, slot_code} == e, "R2/R3/R5/R6 slot",
                          {slot_trail, slot_code}, e);
                    check(!in_ready, "R8 ready low during slot", in_ready, 0);
                end
            end
        end
    end

    task automatic send(input logic [ADDR_W-1:0] a, input int len, input bit pg2);
        logic [ADDR_W-1:0] exp_next;
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_addr = a; in_len = LEN_W'(len); in_pg2 = pg2;
        if (pg2 || len[0]) expq.push_back({1'b0, a[0]});
        if (pg2 && len[0]) expq.push_back({1'b1, ~a[0]});
        exp_next = a + ADDR_W'(len);
        @(negedge clk);
        in_valid = 1'b0;
        check(next_addr == exp_next, "R9 next_addr", next_addr, exp_next);
        check(q_parity == exp_next[0], "R9 q_parity", q_parity, exp_next[0]);
    endtask

    initial begin
        #500000;
        check(0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(in_ready && !slot_valid && next_addr == 0 && !q_parity, "R1 reset state",
              {in_ready, slot_valid, q_parity}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready && !slot_valid, "R1 after release", {in_ready, slot_valid}, 2'b10);

        send(16'h0100, 3, 0);          // R2 aligned odd -> free
        @(negedge clk);
        send(16'h0101, 1, 0);          // R3 misaligned odd -> fetch
        @(negedge clk);
        send(16'h0102, 2, 0);          // R4 even -> no slot
        check(in_ready && !slot_valid, "R4 no slot, ready", {in_ready, slot_valid}, 2'b10);
        send(16'h0104, 4, 0);          // R4 back to back even
        check(in_ready && !slot_valid, "R4 second even", {in_ready, slot_valid}, 2'b10);
        send(16'h0200, 2, 1);          // R5/R7 aligned even page-two
        @(negedge clk);
        send(16'h0201, 4, 1);          // R5/R7 misaligned even page-two
        @(negedge clk);
        send(16'h0300, 3, 1);          // R6 aligned odd: 0 then 1
        // R8: offer while busy, must be ignored
        in_valid = 1'b1; in_addr = 16'h0555; in_len = 4'd1; in_pg2 = 1'b0;
        check(!in_ready, "R8 ready low while busy", in_ready, 0);
        @(negedge clk);
        in_valid = 1'b0;
        check(next_addr == 16'h0303, "R8 ignored offer keeps next_addr", next_addr, 16'h0303);
        @(negedge clk);
        send(16'h0301, 5, 1);          // R6 misaligned odd: 1 then 0
        repeat (2) @(negedge clk);
        send(16'hFFFF, 3, 0);          // R3/R9 wrap to 0x0002
        @(negedge clk);
        send(16'h0002, 7, 0);          // R2
        repeat (3) @(negedge clk);
        check(expq.size() == 0, "R2/R6 all expected slots seen", expq.size(), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule